// File: doc/BRIEF.md
# Serial Word Transmitter With Parity and Gap

This block sends queued words onto a serial line, one bit for each bit-time tick. When the transmitter is enabled and the queue in front of it holds a word, the block takes the head word and sends its data bits least significant bit first. A parity bit follows the data, and then the line stays idle for a fixed gap. Once a word has been sent, the block pops the queue. If the queue still holds a word when the gap ends, the next word starts at once. This continues until the queue is empty.

Each word carries either 24 or 31 data bits, followed by a parity bit that makes the word odd or even. A line-active qualifier marks the bit-times that carry data or parity. If the enable is taken away while a word is on the line, the word is cut off and a sticky integrity flag is raised. The flag stays set until reset.

Top module: `swtx_top`

## Requirements
- R1: After a synchronous reset, serial data, line-active, pop, busy and the integrity flag are all 0.
- R2: With the length select at 0 a word carries data bits 0 to 23 of the head word. With it at 1 the word carries bits 0 to 30. Bit 0 goes first and each bit occupies one tick period, with line-active at 1.
- R3: The bit-time right after the last data bit carries a parity bit, with line-active at 1. With the parity select at 0 the count of ones over the data and parity bits is odd. With it at 1 the count is even.
- R4: Between consecutive words the line spends exactly 4 bit-times with line-active and serial data both at 0. A word therefore occupies 29 bit-times (short) or 36 bit-times (long).
- R5: Each completed word produces exactly one single-cycle pop pulse. Transmission continues while the enable is high and the queue is not empty. Busy returns to 0 after the gap that follows the last word.
- R6: A burst of 8 words keeps busy high for exactly 232 bit-times with short words and 288 bit-times with long words.
- R7: When the enable is low, or when the queue is empty, no word starts: line-active and busy stay 0 and no pop occurs.
- R8: If the enable goes low while a data or parity bit is on the line, the word is abandoned at the next clock. Line-active and busy fall, no pop is issued, and the integrity flag goes to 1. The flag stays at 1 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| head_word | input | 31 | Word at the head of the queue |
| fifo_empty | input | 1 | Queue holds no word |
| tx_en | input | 1 | Transmit enable |
| long_sel | input | 1 | 1 selects 31 data bits, 0 selects 24 |
| even_sel | input | 1 | 1 selects even parity, 0 selects odd |
| bit_tick | input | 1 | One-cycle strobe marking each bit-time boundary |
| ser_data | output | 1 | Serial data bit |
| line_active | output | 1 | High while a data or parity bit is being sent |
| pop | output | 1 | One-cycle strobe: the head word has been sent |
| busy | output | 1 | A word or its trailing gap is in progress |
| integrity_err | output | 1 | Sticky flag set by a mid-word abort |

## Verification
The hardest case to reach from the ports is an abort that lands strictly inside a word. It has to happen after the first bit is on the line and before the parity bit ends. The clear is slow to reach as well, because only a reset can bring the sticky flag back down. The bench loads long words and waits until line-active rises. It then lets a random number of bit-times pass, all fewer than one word, and only then drops the enable on a clock that lies between ticks. After that it checks that the queue was left untouched and that the flag survives more ticks, and it clears the flag with a reset. The gap and drain timing come from back-to-back bursts of random and saturated words. A monitor rebuilds each word and counts idle and busy bit-times.

// File: rtl/swtx_pkg.sv
package swtx_pkg;

    parameter int unsigned WORD_BITS  = 31;
    parameter int unsigned SHORT_BITS = 24;
    parameter int unsigned GAP_TICKS  = 4;

    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_DATA   = 2'd1,
        PH_PARITY = 2'd2,
        PH_GAP    = 2'd3
    } phase_e;

    typedef struct packed {
        logic long_word;
        logic even_par;
    } frame_cfg_t;

    // Turn a raw XOR of the data bits into the bit that is sent.
    function automatic logic parity_fix(input logic raw_xor, input logic even);
        return even ? raw_xor : ~raw_xor;
    endfunction

endpackage

// File: rtl/swtx_shifter.sv
module swtx_shifter #(
    parameter int unsigned W = swtx_pkg::WORD_BITS
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     load,
    input  logic                     shift,
    input  logic [W-1:0]             word_i,
    input  logic [$clog2(W+1)-1:0]   nbits_i,
    output logic                     bit_o,
    output logic                     xor_o
);
    logic [W-1:0] sr_q;
    logic         xor_q;
    logic         acc;

    // XOR over the bits that will actually go out.
    always_comb begin
        acc = 1'b0;
        for (int unsigned i = 0; i < W; i++) begin
            if (i < 32'(nbits_i)) acc = acc ^ word_i[i];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sr_q  <= '0;
            xor_q <= 1'b0;
        end else if (load) begin
            sr_q  <= word_i;
            xor_q <= acc;
        end else if (shift) begin
            sr_q  <= sr_q >> 1;
        end
    end

    assign bit_o = sr_q[0];
    assign xor_o = xor_q;

    // R2
    shift_load_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(load && shift));

endmodule

// File: rtl/swtx_bitcount.sv
module swtx_bitcount #(
    parameter int unsigned W = swtx_pkg::WORD_BITS
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     clear,
    input  logic                     inc,
    input  logic [$clog2(W+1)-1:0]   limit_i,
    output logic                     last_o
);
    localparam int unsigned CW = $clog2(W + 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)        cnt_q <= '0;
        else if (clear) cnt_q <= '0;
        else if (inc)   cnt_q <= cnt_q + 1'b1;
    end

    assign last_o = (cnt_q == limit_i - 1'b1);

    // R2
    bit_range_chk: assert property (@(posedge clk) disable iff (rst)
        cnt_q < limit_i);

endmodule

// File: rtl/swtx_gaptimer.sv
module swtx_gaptimer #(
    parameter int unsigned GAP = swtx_pkg::GAP_TICKS
) (
    input  logic clk,
    input  logic rst,
    input  logic clear,
    input  logic inc,
    output logic done_o
);
    localparam int unsigned GW = $clog2(GAP + 1);

    logic [GW-1:0] g_q;

    always_ff @(posedge clk) begin
        if (rst)        g_q <= '0;
        else if (clear) g_q <= '0;
        else if (inc)   g_q <= g_q + 1'b1;
    end

    assign done_o = (g_q == GW'(GAP - 1));

    // R4
    gap_range_chk: assert property (@(posedge clk) disable iff (rst)
        g_q < GW'(GAP));

endmodule

// File: rtl/swtx_top.sv
module swtx_top
    import swtx_pkg::*;
#(
    parameter int unsigned W   = WORD_BITS,
    parameter int unsigned SW  = SHORT_BITS,
    parameter int unsigned GAP = GAP_TICKS
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] head_word,
    input  logic         fifo_empty,
    input  logic         tx_en,
    input  logic         long_sel,
    input  logic         even_sel,
    input  logic         bit_tick,
    output logic         ser_data,
    output logic         line_active,
    output logic         pop,
    output logic         busy,
    output logic         integrity_err
);
    localparam int unsigned CW = $clog2(W + 1);
    localparam logic [CW-1:0] LEN_LONG  = CW'(W);
    localparam logic [CW-1:0] LEN_SHORT = CW'(SW);

    phase_e     ph_q, ph_d;
    frame_cfg_t cfg_q;
    logic       pop_q, err_q;

    logic [CW-1:0] nbits_now, nbits_q;
    logic in_word, abort, can_start, start;
    logic shift, last_bit, gap_done, gap_clr, gap_inc;
    logic sr_bit, raw_xor;

    assign nbits_now = long_sel ? LEN_LONG : LEN_SHORT;
    assign nbits_q   = cfg_q.long_word ? LEN_LONG : LEN_SHORT;

    assign in_word   = (ph_q == PH_DATA) || (ph_q == PH_PARITY);
    assign abort     = in_word && !tx_en;
    assign can_start = bit_tick && tx_en && !fifo_empty;
    assign start     = can_start && ((ph_q == PH_IDLE) || ((ph_q == PH_GAP) && gap_done));
    assign shift     = !abort && bit_tick && (ph_q == PH_DATA) && !last_bit;
    assign gap_clr   = (ph_q == PH_PARITY) && bit_tick && tx_en;
    assign gap_inc   = (ph_q == PH_GAP) && bit_tick && !gap_done;

    swtx_shifter #(.W(W)) u_shift (
        .clk     (clk),
        .rst     (rst),
        .load    (start),
        .shift   (shift),
        .word_i  (head_word),
        .nbits_i (nbits_now),
        .bit_o   (sr_bit),
        .xor_o   (raw_xor)
    );

    swtx_bitcount #(.W(W)) u_bits (
        .clk     (clk),
        .rst     (rst),
        .clear   (start),
        .inc     (shift),
        .limit_i (nbits_q),
        .last_o  (last_bit)
    );

    swtx_gaptimer #(.GAP(GAP)) u_gap (
        .clk    (clk),
        .rst    (rst),
        .clear  (gap_clr),
        .inc    (gap_inc),
        .done_o (gap_done)
    );

    always_comb begin
        ph_d = ph_q;
        unique case (ph_q)
            PH_IDLE:   if (start) ph_d = PH_DATA;
            PH_DATA: begin
                if (abort)                     ph_d = PH_IDLE;
                else if (bit_tick && last_bit) ph_d = PH_PARITY;
            end
            PH_PARITY: begin
                if (abort)         ph_d = PH_IDLE;
                else if (bit_tick) ph_d = PH_GAP;
            end
            PH_GAP: begin
                if (bit_tick && gap_done) ph_d = start ? PH_DATA : PH_IDLE;
            end
            default: ph_d = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ph_q  <= PH_IDLE;
            cfg_q <= '0;
            pop_q <= 1'b0;
            err_q <= 1'b0;
        end else begin
            ph_q  <= ph_d;
            pop_q <= gap_clr;
            err_q <= err_q | abort;
            if (start) cfg_q <= '{long_word: long_sel, even_par: even_sel};
        end
    end

    always_comb begin
        unique case (ph_q)
            PH_DATA:   ser_data = sr_bit;
            PH_PARITY: ser_data = parity_fix(raw_xor, cfg_q.even_par);
            default:   ser_data = 1'b0;
        endcase
    end

    assign line_active   = in_word;
    assign busy          = (ph_q != PH_IDLE);
    assign pop           = pop_q;
    assign integrity_err = err_q;

    // R8
    abort_stop_chk: assert property (@(posedge clk) disable iff (rst)
        (in_word && !tx_en) |=> (!line_active && !busy && integrity_err));
    // R8
    err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        integrity_err |=> integrity_err);
    // R5
    pop_single_chk: assert property (@(posedge clk) disable iff (rst)
        pop |=> !pop);
    // R5
    pop_in_gap_chk: assert property (@(posedge clk) disable iff (rst)
        pop |-> (ph_q == PH_GAP));
    // R7
    no_start_chk: assert property (@(posedge clk) disable iff (rst)
        ((ph_q == PH_IDLE) && (!tx_en || fifo_empty)) |=> (ph_q == PH_IDLE));

endmodule

// File: tb/swtx_top_test.sv
`timescale 1ns/1ps
module swtx_top_test;

    localparam int TICK_DIV = 4;
    localparam int GAP      = 4;

    logic        clk = 1'b0;
    logic        rst;
    logic [30:0] head_word;
    logic        fifo_empty, tx_en, long_sel, even_sel, bit_tick;
    logic        ser_data, line_active, pop, busy, integrity_err;

    always #4 clk = ~clk;

    swtx_top uut (
        .clk(clk), .rst(rst), .head_word(head_word), .fifo_empty(fifo_empty),
        .tx_en(tx_en), .long_sel(long_sel), .even_sel(even_sel), .bit_tick(bit_tick),
        .ser_data(ser_data), .line_active(line_active), .pop(pop), .busy(busy),
        .integrity_err(integrity_err)
    );

    logic [30:0] fifo_q[$];
    logic [30:0] exp_q[$];
    int tests = 0, fails = 0;
    int div_cnt = 0;
    logic [31:0] rx_bits;
    int  rx_len = 0, idle_run = 0, words_seen = 0, busy_bits = 0, pops = 0;
    bit  cur_long = 0, cur_even = 0, abort_mode = 0, gap_bad = 0, any_active = 0;
    bit  done_run = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic logic exp_par(input logic [30:0] w, input bit lng, input bit evn);
        logic x = 1'b0;
        int n = lng ? 31 : 24;
        for (int i = 0; i < n; i++) x ^= w[i];
        return evn ? x : ~x;
    endfunction

    task automatic finish_word();
        int n;
        logic [30:0] w, mask, got;
        n = rx_len - 1;
        if (abort_mode) begin
            rx_len = 0;
            return;
        end
        words_seen++;
        w = (exp_q.size() > 0) ? exp_q.pop_front() : 31'h0;
        mask = cur_long ? 31'h7FFF_FFFF : 31'h00FF_FFFF;
        got  = rx_bits[30:0] & mask;
        // R2 length, LSB-first data
        check(n == (cur_long ? 31 : 24), "R2", "data bits per word", n, cur_long ? 31 : 24);
        check(got == (w & mask), "R2", "received data", int'(got), int'(w & mask));
        // R3 parity bit after data
        check(rx_bits[n] == exp_par(w, cur_long, cur_even), "R3", "parity bit",
              int'(rx_bits[n]), int'(exp_par(w, cur_long, cur_even)));
        rx_len = 0;
    endtask

    task automatic sample_bit();
        if (busy) busy_bits++;
        if (line_active) begin
            any_active = 1;
            if (rx_len == 0) begin
                // R4 exact gap between consecutive words
                if (words_seen > 0 && !abort_mode)
                    check(idle_run == GAP, "R4", "idle bit-times between words", idle_run, GAP);
                idle_run = 0;
            end
            if (rx_len < 32) rx_bits[rx_len] = ser_data;
            rx_len++;
        end else begin
            if (rx_len > 0) finish_word();
            if (ser_data) gap_bad = 1;
            idle_run++;
        end
    endtask

    // bit-rate strobe, queue model and line monitor
    initial begin
        bit_tick = 0; head_word = '0; fifo_empty = 1;
        forever begin
            @(negedge clk);
            if (pop) begin
                pops++;
                if (fifo_q.size() > 0) void'(fifo_q.pop_front());
            end
            if (div_cnt == TICK_DIV - 1) begin
                sample_bit();
                bit_tick = 1;
                div_cnt = 0;
            end else begin
                bit_tick = 0;
                div_cnt++;
            end
            head_word  = (fifo_q.size() > 0) ? fifo_q[0] : 31'h0;
            fifo_empty = (fifo_q.size() == 0);
        end
    end

    task automatic run_burst(input int k, input bit lng, input bit evn,
                             input bit directed, input logic [30:0] dw);
        logic [30:0] w;
        int per;
        @(negedge clk);
        long_sel = lng; even_sel = evn; cur_long = lng; cur_even = evn;
        for (int i = 0; i < k; i++) begin
            w = directed ? dw : 31'($urandom);
            fifo_q.push_back(w);
            exp_q.push_back(w);
        end
        repeat (3) @(negedge clk);
        busy_bits = 0; words_seen = 0; pops = 0; gap_bad = 0; idle_run = 0;
        tx_en = 1;
        do @(negedge clk); while (!(fifo_q.size() == 0 && !busy));
        tx_en = 0;
        repeat (3 * TICK_DIV) @(negedge clk);
        per = (lng ? 31 : 24) + 1 + GAP;
        // R5 one pop per word, all words sent
        check(pops == k, "R5", "pop pulses", pops, k);
        check(words_seen == k, "R5", "words on line", words_seen, k);
        check(!busy, "R5", "busy after drain", int'(busy), 0);
        // R4 / R6 total bit-times
        if (k == 8) check(busy_bits == 8 * per, "R6", "drain bit-times", busy_bits, 8 * per);
        else        check(busy_bits == k * per, "R4", "burst bit-times", busy_bits, k * per);
        check(!gap_bad, "R4", "serial data during idle", int'(gap_bad), 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        int nwait;
        void'($urandom(32'd7741));
        rst = 1; tx_en = 0; long_sel = 0; even_sel = 0;
        repeat (4) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1 reset state
        check(!ser_data && !line_active && !pop && !busy && !integrity_err, "R1",
              "outputs after reset",
              int'({ser_data, line_active, pop, busy, integrity_err}), 0);

        // R7: enabled with empty queue
        any_active = 0; pops = 0;
        tx_en = 1;
        repeat (12 * TICK_DIV) @(negedge clk);
        tx_en = 0;
        check(!any_active && !busy, "R7", "activity with empty queue", int'(any_active), 0);
        // R7: words queued but disabled
        fifo_q.push_back(31'h1234567); fifo_q.push_back(31'h7654321);
        repeat (12 * TICK_DIV) @(negedge clk);
        check(!any_active && pops == 0 && fifo_q.size() == 2, "R7",
              "activity while disabled", int'(any_active) + pops, 0);
        fifo_q.delete();
        repeat (2) @(negedge clk);

        // directed corners
        run_burst(1, 0, 0, 1, 31'h0);            // R3 all zero, odd -> parity 1
        run_burst(2, 0, 1, 1, 31'h7FFF_FFFF);    // R3 24 ones even -> parity 0
        run_burst(1, 1, 0, 1, 31'h7FFF_FFFF);    // R3 31 ones odd -> parity 0
        run_burst(1, 0, 0, 1, 31'h0000_0001);    // R2 LSB first
        run_burst(8, 0, 0, 0, 31'h0);            // R6 short drain
        run_burst(8, 1, 1, 0, 31'h0);            // R6 long drain

        // constrained random bursts
        for (int r = 0; r < 8; r++)
            run_burst(1 + int'($urandom % 8), bit'($urandom % 2), bit'($urandom % 2), 0, 31'h0);

        // R8 abort inside a word
        abort_mode = 1; pops = 0;
        long_sel = 1; even_sel = 0;
        for (int i = 0; i < 3; i++) fifo_q.push_back(31'($urandom));
        repeat (3) @(negedge clk);
        tx_en = 1;
        do @(negedge clk); while (!line_active);
        nwait = 2 + int'($urandom % 20);
        repeat (nwait * TICK_DIV + 1) @(negedge clk);
        tx_en = 0;
        @(negedge clk);
        check(!line_active && !busy, "R8", "line after abort",
              int'({line_active, busy}), 0);
        check(integrity_err, "R8", "flag after abort", int'(integrity_err), 1);
        check(pops == 0 && fifo_q.size() == 3, "R8", "queue untouched by abort",
              fifo_q.size(), 3);
        repeat (10 * TICK_DIV) @(negedge clk);
        check(integrity_err, "R8", "flag is sticky", int'(integrity_err), 1);
        rst = 1;
        fifo_q.delete(); exp_q.delete();
        repeat (2) @(negedge clk);
        rst = 0;
        @(negedge clk);
        check(!integrity_err, "R8", "flag cleared by reset", int'(integrity_err), 0);
        abort_mode = 0;

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule